// File: doc/BRIEF.md
# Banked Square-Array Word Memory

This block is a single-port word memory assembled from a grid of one-bit storage squares. Each square holds `ROWS x COLS` bits. A bank row places `WIDTH` squares side by side, one for each bit of the data word. `BANKS` bank rows are stacked to give the full depth.

The word address is decoded in three stages. The most significant field drives a one-hot chip-select decoder that picks a single bank row. The middle field names the row inside every square of that bank. The least significant field names the column. Read and write data share one bidirectional data bus. The memory drives that bus only in the cycle after a read request, and it raises `rd_drive` while it does so. In every other cycle the bus is left in high impedance, so an external master can place write data on it.

The default configuration is small: 4 banks, 8 x 8 squares and an 8-bit word, giving 256 words. The same RTL scales to a 16-bank, 512 x 512, 32-bit memory through its parameters alone.

Top module: `sqmem_top`

## Requirements
- R1: Address bits [ADDR_W-1 -: BANK_BITS] select the bank row, the next ROW_BITS bits select the row inside each square, and the low COL_BITS bits select the column. Every one of the 2^ADDR_W addresses reaches its own distinct word.
- R2: A read request (`ce`=1, `we`=0 at a rising edge) causes the memory to drive the word at that address on `data_io`, with `rd_drive`=1, during the following clock cycle.
- R3: After reset, in any cycle that follows an idle cycle (`ce`=0), and in any cycle that follows a write request, `rd_drive` is 0 and the memory does not drive `data_io`.
- R4: A write (`ce`=1, `we`=1 at a rising edge) stores `data_io` at the addressed word. Words at the same row and column in the other banks keep their contents.
- R5: With `ce`=0, `we` and `data_io` have no effect on stored contents, and no chip-select is active.
- R6: While `ce`=1, exactly one bank chip-select is asserted.
- R7: A read leaves the stored contents unchanged.
- R8: Every data bit is stored and returned independently of the other bits, so a single set bit in any position reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the read-drive state |
| ce | input | 1 | Access enable |
| we | input | 1 | 1 = write, 0 = read when `ce`=1 |
| addr | input | ADDR_W | Word address: bank, row, column fields |
| data_io | inout | WIDTH | Shared data bus: write data in, read data out |
| rd_drive | output | 1 | High while the memory drives `data_io` |

## Verification
The hardest case to reach is a write into one bank that disturbs the same row and column in a neighbouring bank. A square-grid decode error shows up only there, because the row and column fields are shared by every bank. The bench first fills all 256 words with an address-derived pattern. It then rewrites single words and reads back the same row and column in every other bank. A second full sweep confirms that the reads disturbed nothing. A final pass writes with `ce` low over a known word and confirms that the word is unchanged.

// File: rtl/sqmem_pkg.sv
package sqmem_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_t;

  function automatic acc_t classify(input logic ce, input logic we);
    if (!ce) return ACC_IDLE;
    return we ? ACC_WRITE : ACC_READ;
  endfunction
endpackage

// File: rtl/sqmem_addr_split.sv
module sqmem_addr_split #(
  parameter int BANK_BITS = 2,
  parameter int ROW_BITS  = 3,
  parameter int COL_BITS  = 3,
  localparam int ADDR_W   = BANK_BITS + ROW_BITS + COL_BITS
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [BANK_BITS-1:0] bank,
  output logic [ROW_BITS-1:0]  row,
  output logic [COL_BITS-1:0]  col
);
  assign bank = addr[ADDR_W-1 -: BANK_BITS];
  assign row  = addr[COL_BITS +: ROW_BITS];
  assign col  = addr[COL_BITS-1:0];
endmodule

// File: rtl/sqmem_bank_dec.sv
module sqmem_bank_dec #(
  parameter int BANK_BITS = 2,
  localparam int BANKS    = 1 << BANK_BITS
) (
  input  logic                 en,
  input  logic [BANK_BITS-1:0] bank,
  output logic [BANKS-1:0]     cs
);
  for (genvar b = 0; b < BANKS; b++) begin : g_sel
    assign cs[b] = en && (bank == BANK_BITS'(b));
  end
endmodule

// File: rtl/sqmem_bitsq.sv
module sqmem_bitsq #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  localparam int IDX_W   = ROW_BITS + COL_BITS,
  localparam int DEPTH   = 1 << IDX_W
) (
  input  logic                clk,
  input  logic                cs,
  input  logic                we,
  input  logic [ROW_BITS-1:0] row,
  input  logic [COL_BITS-1:0] col,
  input  logic                wbit,
  output logic                rbit
);
  logic             cells [DEPTH];
  logic [IDX_W-1:0] idx;

  assign idx = {row, col};

  always_ff @(posedge clk) begin
    if (cs && we) cells[idx] <= wbit;
  end

  always_ff @(posedge clk) begin
    if (cs && !we) rbit <= cells[idx];
  end
endmodule

// File: rtl/sqmem_rdsel.sv
module sqmem_rdsel #(
  parameter int BANKS = 4,
  parameter int WIDTH = 8
) (
  input  logic [BANKS-1:0]            sel,
  input  logic [BANKS-1:0][WIDTH-1:0] bits,
  output logic [WIDTH-1:0]            word
);
  always_comb begin
    word = '0;
    for (int b = 0; b < BANKS; b++) begin
      word = word | (bits[b] & {WIDTH{sel[b]}});
    end
  end
endmodule

// File: rtl/sqmem_top.sv
module sqmem_top #(
  parameter int BANK_BITS = 2,
  parameter int ROW_BITS  = 3,
  parameter int COL_BITS  = 3,
  parameter int WIDTH     = 8,
  localparam int ADDR_W   = BANK_BITS + ROW_BITS + COL_BITS,
  localparam int BANKS    = 1 << BANK_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [WIDTH-1:0]  data_io,
  output logic              rd_drive
);
  import sqmem_pkg::*;

  logic [BANK_BITS-1:0]            bank;
  logic [ROW_BITS-1:0]             row;
  logic [COL_BITS-1:0]             col;
  logic [BANKS-1:0]                cs;
  logic [BANKS-1:0]                bank_q;
  logic [BANKS-1:0][WIDTH-1:0]     rbits;
  logic [WIDTH-1:0]                rd_word;
  logic [WIDTH-1:0]                wr_word;
  logic                            rd_oe_q;
  acc_t                            acc;

  assign acc     = classify(ce, we);
  assign wr_word = data_io;

  sqmem_addr_split #(
    .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)
  ) u_split (
    .addr(addr), .bank(bank), .row(row), .col(col)
  );

  sqmem_bank_dec #(.BANK_BITS(BANK_BITS)) u_dec (
    .en(ce), .bank(bank), .cs(cs)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar w = 0; w < WIDTH; w++) begin : g_bit
      sqmem_bitsq #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_sq (
        .clk (clk),
        .cs  (cs[b]),
        .we  (we),
        .row (row),
        .col (col),
        .wbit(wr_word[w]),
        .rbit(rbits[b][w])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_oe_q <= 1'b0;
      bank_q  <= '0;
    end else begin
      rd_oe_q <= (acc == ACC_READ);
      bank_q  <= (acc == ACC_READ) ? cs : '0;
    end
  end

  sqmem_rdsel #(.BANKS(BANKS), .WIDTH(WIDTH)) u_rdsel (
    .sel(bank_q), .bits(rbits), .word(rd_word)
  );

  assign data_io  = rd_oe_q ? rd_word : 'z;
  assign rd_drive = rd_oe_q;
endmodule

// File: rtl/sqmem_chk.sv
module sqmem_chk #(
  parameter int BANKS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic             we,
  input logic [BANKS-1:0] cs,
  input logic [BANKS-1:0] bank_q,
  input logic             rd_drive
);
  p_cs_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    ce |-> $onehot(cs));

  p_cs_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !ce |-> (cs == '0));

  p_read_drive_r2: assert property (@(posedge clk) disable iff (rst)
    (ce && !we) |=> rd_drive);

  p_hiz_r3: assert property (@(posedge clk) disable iff (rst)
    (!ce || we) |=> !rd_drive);

  p_bank_track_r1: assert property (@(posedge clk) disable iff (rst)
    (ce && !we) |=> (bank_q == $past(cs)));

  p_drive_one_bank_r6: assert property (@(posedge clk) disable iff (rst)
    rd_drive |-> $onehot(bank_q));
endmodule

bind sqmem_top sqmem_chk #(.BANKS(BANKS)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .we(we),
  .cs(cs), .bank_q(bank_q), .rd_drive(rd_drive)
);

// File: tb/sim_sqmem_top.sv
`timescale 1ns/1ps
module sim_sqmem_top;
  localparam int AW = 8;
  localparam int W  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce  = 1'b0;
  logic          we  = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          tb_drv = 1'b0;
  logic [W-1:0]  tb_val = '0;
  wire  [W-1:0]  bus;
  logic          rd_drive;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  assign bus = tb_drv ? tb_val : 'z;

  always #2.5 clk = ~clk;

  sqmem_top u0 (
    .clk(clk), .rst(rst), .ce(ce), .we(we), .addr(addr),
    .data_io(bus), .rd_drive(rd_drive)
  );

  function automatic logic [W-1:0] pat(input int a, input int pass);
    return W'((a * 37 + 11 + pass * 101) ^ (a >> 3));
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    ce = 1'b1; we = 1'b1; addr = AW'(a); tb_drv = 1'b1; tb_val = d;
    @(negedge clk);
    ce = 1'b0; we = 1'b0; tb_drv = 1'b0;
    chk("R3 write no drive", W'(rd_drive), '0);
  endtask

  task automatic rd(input int a, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    ce = 1'b1; we = 1'b0; addr = AW'(a);
    @(negedge clk);
    ce = 1'b0;
    chk("R2 drive", W'(rd_drive), W'(1));
    chk(req, bus, exp);
    @(negedge clk);
    chk("R3 idle no drive", W'(rd_drive), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 reset", W'(rd_drive), '0);

    // R1 exhaustive fill and readback of every address
    for (int a = 0; a < 256; a++) wr(a, pat(a, 0));
    for (int a = 0; a < 256; a++) rd(a, pat(a, 0), "R1 sweep");
    // R7 second read pass sees the same data
    for (int a = 0; a < 256; a++) rd(a, pat(a, 0), "R7 reread");

    // R4 write one bank, other banks at same row/col untouched
    for (int b = 0; b < 4; b++) begin
      for (int rc = 0; rc < 64; rc += 9) begin
        wr(b * 64 + rc, pat(b * 64 + rc, 1));
        for (int o = 0; o < 4; o++) begin
          if (o != b) rd(o * 64 + rc, (o < b) ? pat(o * 64 + rc, 1) : pat(o * 64 + rc, 0), "R4 other bank");
          else        rd(o * 64 + rc, pat(o * 64 + rc, 1), "R4 own bank");
        end
      end
    end

    // R8 walking single bit per position
    for (int i = 0; i < W; i++) begin
      wr(200, W'(1) << i);
      rd(200, W'(1) << i, "R8 walking bit");
    end

    // R5 write attempt with ce low is ignored
    wr(17, 8'h5A);
    @(negedge clk);
    ce = 1'b0; we = 1'b1; addr = AW'(17); tb_drv = 1'b1; tb_val = 8'hA5;
    @(negedge clk);
    chk("R5 no drive", W'(rd_drive), '0);
    we = 1'b0; tb_drv = 1'b0;
    rd(17, 8'h5A, "R5 ignored write");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int n = 0; n < 150000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule